// File: doc/BRIEF.md
# Reset and Power Mode Sequencer

This block produces the stretched system reset for a microcontroller core and keeps track of the operating mode: normal, idle or powerdown. A reset cycle can be started in two ways. One is a falling edge on the external active-low reset pin. The other is a one-cycle internal reset request. Either one turns on the open-drain pull-down enable for the reset pin for a fixed number of state times. The core reset is held for as long as the pin is low and for the whole pull-down window. A slow state-time tick from an outside divider paces the window.

During reset the block samples a strap pin. If the strap is low, a test-mode flag is latched, and the flag keeps its value until the next reset. The reset vector depends on the code memory select input. Software requests idle and powerdown. Powerdown is allowed only when the configuration enable bit is set. The block leaves idle on an unmasked interrupt. It leaves powerdown without a reset when a wake pin is held low for a minimum pulse width. That exit turns the phase clocks back on, but the oscillator enable stays off until the next reset.

Top module: `rpm_seq`

## Requirements
- R1: A falling edge on the synchronized reset pin, or a cycle with `int_rst_req` high, sets `pin_pulldown_en` on the next clock edge. The output stays high for exactly 16 `state_tick` pulses, counted from the cycle after the trigger, and drops on the edge that samples the 16th pulse. After `rst_n` is released, a 16-tick window is already running.
- R2: A trigger that arrives while a window is running restarts the count. The window then lasts 16 ticks from the new trigger, and any tick in the trigger cycle is not counted.
- R3: Both input pins pass through a two-flop synchronizer. `core_reset` is high while the synchronized reset pin is low or the pull-down window is active. It stays high past the end of the window while the pin is still held low.
- R4: Any core reset while in idle or powerdown returns `mode` to normal (2'b00) and sets `osc_en` to 1.
- R5: `reset_vector` is 24'hFF2080 when `mem_internal` is 1 and 24'h0F2080 when it is 0.
- R6: While `core_reset` is high, `test_mode` takes the inverse of `strap_pin` at each edge. As a result, a low strap at release gives a flag of 1 and a high strap gives 0. While `core_reset` is low, the flag does not change.
- R7: A `pd_req` in normal mode moves to powerdown (2'b10) only when `pd_enable` is 1. When `pd_enable` is 0 the request has no effect.
- R8: In powerdown, a synchronized low on `wake_pin_n` for 3 consecutive cycles returns `mode` to normal without raising `core_reset`. Shorter low pulses leave the mode in powerdown.
- R9: `phase_clk_en` is 0 only in powerdown. `osc_en` is cleared on powerdown entry, stays 0 after a wake-pin exit, and is set again only by a core reset.
- R10: In normal mode, `idle_req` moves to idle (2'b01) unless an enabled powerdown request is present in the same cycle; powerdown wins. Idle returns to normal on `irq_pending`. Requests made while `core_reset` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low |
| ext_rst_pin_n | input | 1 | External reset pin level, active low, asynchronous |
| int_rst_req | input | 1 | Internal reset request, one cycle |
| pd_enable | input | 1 | Powerdown enable configuration bit |
| pd_req | input | 1 | Powerdown request |
| idle_req | input | 1 | Idle request |
| irq_pending | input | 1 | Any unmasked interrupt pending |
| wake_pin_n | input | 1 | Powerdown exit pin, active low, asynchronous |
| strap_pin | input | 1 | Test-mode strap, low selects test mode |
| mem_internal | input | 1 | 1 = execute from internal memory |
| state_tick | input | 1 | One-cycle state-time pulse from the divider |
| pin_pulldown_en | output | 1 | Enable of the reset pin pull-down transistor |
| core_reset | output | 1 | Reset to the core, active high |
| test_mode | output | 1 | Latched test-mode flag |
| reset_vector | output | 24 | Address of the first fetch after reset |
| mode | output | 2 | 00 normal, 01 idle, 10 powerdown |
| phase_clk_en | output | 1 | Phase clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
Some rules are checked by assertions on every cycle:
- a trigger starts a fresh window;
- the window can only close on a tick;
- a core reset forces normal mode;
- powerdown is never entered with the enable bit clear;
- the oscillator is off in powerdown;
- idle persists without an interrupt;
- a powerdown exit that is not caused by a reset follows a low wake sample;
- the test flag is frozen outside reset.

Other behaviour needs the bench's scenarios, which it checks against a cycle-by-cycle reference model:
- the exact 16-tick length;
- the restart on a mid-window trigger;
- the reset held past the window by a long pin low;
- the rejection of a short wake pulse;
- the oscillator staying off after a pin wake.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_IDLE   = 2'b01,
    MODE_PDOWN  = 2'b10
  } rpm_mode_e;

endpackage

// File: rtl/rpm_sync.sv
module rpm_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= RST_VAL;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rpm_stretch.sv
module rpm_stretch #(
  parameter int STATES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic tick_i,
  output logic active_o
);

  localparam int CNT_W = (STATES > 1) ? $clog2(STATES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STATES - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             count_en;

  assign count_en = active_q && tick_i;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (trig_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (count_en) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

  AST_TRIG_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (active_q && cnt_q == '0)); // R1
  AST_CLOSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(tick_i) && !$past(trig_i))); // R1
  AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0 && trig_i) |=> cnt_q == '0); // R2

endmodule

// File: rtl/rpm_mode_ctl.sv
module rpm_mode_ctl
  import rpm_pkg::*;
#(
  parameter int WAKE_MIN = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      core_reset_i,
  input  logic      pd_enable_i,
  input  logic      pd_req_i,
  input  logic      idle_req_i,
  input  logic      irq_i,
  input  logic      wake_s_i,
  output rpm_mode_e mode_o,
  output logic      phase_en_o,
  output logic      osc_en_o
);

  localparam int WCNT_W = (WAKE_MIN > 1) ? $clog2(WAKE_MIN) : 1;
  localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(WAKE_MIN - 1);

  rpm_mode_e         mode_q, mode_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              osc_q, osc_d;
  logic              pd_go;

  assign pd_go = pd_req_i && pd_enable_i;

  always_comb begin
    mode_d = mode_q;
    wcnt_d = '0;
    osc_d  = osc_q;
    if (core_reset_i) begin
      mode_d = MODE_NORMAL;
      osc_d  = 1'b1;
    end else begin
      unique case (mode_q)
        MODE_NORMAL: begin
          if (pd_go) begin
            mode_d = MODE_PDOWN;
            osc_d  = 1'b0;
          end else if (idle_req_i) begin
            mode_d = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irq_i) mode_d = MODE_NORMAL;
        end
        MODE_PDOWN: begin
          if (!wake_s_i) begin
            if (wcnt_q == WLAST) begin
              mode_d = MODE_NORMAL;
            end else begin
              wcnt_d = wcnt_q + 1'b1;
            end
          end
        end
        default: mode_d = MODE_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      wcnt_q <= '0;
      osc_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      wcnt_q <= wcnt_d;
      osc_q  <= osc_d;
    end
  end

  assign mode_o     = mode_q;
  assign phase_en_o = (mode_q != MODE_PDOWN);
  assign osc_en_o   = osc_q;

  AST_RESET_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_i |=> mode_q == MODE_NORMAL); // R4
  AST_PD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_enable_i && mode_q != MODE_PDOWN) |=> mode_q != MODE_PDOWN); // R7
  AST_WAKE_BY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_PDOWN && mode_q == MODE_NORMAL && !$past(core_reset_i))
      |-> !$past(wake_s_i)); // R8
  AST_OSC_OFF_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PDOWN) |-> !osc_q); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && !irq_i && !core_reset_i) |=> mode_q == MODE_IDLE); // R10

endmodule

// File: rtl/rpm_seq.sv
module rpm_seq
  import rpm_pkg::*;
#(
  parameter int               STRETCH_STATES  = 16,
  parameter int               WAKE_MIN_CYCLES = 3,
  parameter int               SYNC_STAGES     = 2,
  parameter int               VEC_W           = 24,
  parameter logic [VEC_W-1:0] INT_VECTOR      = 24'hFF2080,
  parameter logic [VEC_W-1:0] EXT_VECTOR      = 24'h0F2080
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_pin_n,
  input  logic             int_rst_req,
  input  logic             pd_enable,
  input  logic             pd_req,
  input  logic             idle_req,
  input  logic             irq_pending,
  input  logic             wake_pin_n,
  input  logic             strap_pin,
  input  logic             mem_internal,
  input  logic             state_tick,
  output logic             pin_pulldown_en,
  output logic             core_reset,
  output logic             test_mode,
  output logic [VEC_W-1:0] reset_vector,
  output logic [1:0]       mode,
  output logic             phase_clk_en,
  output logic             osc_en
);

  localparam int PIN_N = 2;
  localparam int P_EXT  = 1;
  localparam int P_WAKE = 0;

  logic [PIN_N-1:0] pins_s;
  logic             ext_s, wake_s;
  logic             ext_prev_q, ext_prev_d;
  logic             trig;
  logic             window_act;
  logic             tm_q, tm_d;
  rpm_mode_e        mode_st;

  rpm_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_pin_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ext_rst_pin_n, wake_pin_n}),
    .sync_o (pins_s)
  );

  assign ext_s  = pins_s[P_EXT];
  assign wake_s = pins_s[P_WAKE];

  assign ext_prev_d = ext_s;
  assign trig       = (ext_prev_q && !ext_s) || int_rst_req;

  rpm_stretch #(
    .STATES(STRETCH_STATES)
  ) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig),
    .tick_i  (state_tick),
    .active_o(window_act)
  );

  assign core_reset      = window_act || !ext_s;
  assign pin_pulldown_en = window_act;

  assign tm_d = core_reset ? !strap_pin : tm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q <= 1'b1;
      tm_q       <= 1'b0;
    end else begin
      ext_prev_q <= ext_prev_d;
      tm_q       <= tm_d;
    end
  end

  assign test_mode    = tm_q;
  assign reset_vector = mem_internal ? INT_VECTOR : EXT_VECTOR;

  rpm_mode_ctl #(
    .WAKE_MIN(WAKE_MIN_CYCLES)
  ) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_reset_i(core_reset),
    .pd_enable_i (pd_enable),
    .pd_req_i    (pd_req),
    .idle_req_i  (idle_req),
    .irq_i       (irq_pending),
    .wake_s_i    (wake_s),
    .mode_o      (mode_st),
    .phase_en_o  (phase_clk_en),
    .osc_en_o    (osc_en)
  );

  assign mode = mode_st;

  AST_TM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !core_reset |=> $stable(tm_q)); // R6
  AST_PULLDOWN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_pulldown_en) |-> core_reset); // R3

endmodule

// File: tb/rpm_seq_bench.sv
module rpm_seq_bench;

  localparam int WIN  = 16;
  localparam int WMIN = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_rst_pin_n, int_rst_req, pd_enable, pd_req, idle_req, irq_pending;
  logic wake_pin_n, strap_pin, mem_internal, state_tick;
  logic pin_pulldown_en, core_reset, test_mode, phase_clk_en, osc_en;
  logic [23:0] reset_vector;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rpm_seq u_rpm_seq (
    .clk(clk), .rst_n(rst_n), .ext_rst_pin_n(ext_rst_pin_n), .int_rst_req(int_rst_req),
    .pd_enable(pd_enable), .pd_req(pd_req), .idle_req(idle_req), .irq_pending(irq_pending),
    .wake_pin_n(wake_pin_n), .strap_pin(strap_pin), .mem_internal(mem_internal),
    .state_tick(state_tick), .pin_pulldown_en(pin_pulldown_en), .core_reset(core_reset),
    .test_mode(test_mode), .reset_vector(reset_vector), .mode(mode),
    .phase_clk_en(phase_clk_en), .osc_en(osc_en)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin histories as queues, plain integers for state
  bit ext_hist[$];
  bit wake_hist[$];
  bit m_prev, m_act, m_tm, m_osc;
  int m_cnt, m_mode, m_wlow;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_hist = '{1'b1, 1'b1};
      wake_hist = '{1'b1, 1'b1};
      m_prev = 1; m_act = 1; m_cnt = 0; m_tm = 0; m_osc = 1; m_mode = 0; m_wlow = 0;
    end else begin
      bit es, ws, in_rst, fire;
      es = ext_hist[1];
      ws = wake_hist[1];
      in_rst = m_act || !es;
      fire = (m_prev && !es) || int_rst_req;
      if (fire) begin m_act = 1; m_cnt = 0; end
      else if (m_act && state_tick) begin
        m_cnt++;
        if (m_cnt == WIN) begin m_act = 0; m_cnt = 0; end
      end
      if (in_rst) m_tm = !strap_pin;
      if (in_rst) begin m_mode = 0; m_osc = 1; m_wlow = 0; end
      else if (m_mode == 0) begin
        if (pd_req && pd_enable) begin m_mode = 2; m_osc = 0; end
        else if (idle_req) m_mode = 1;
      end else if (m_mode == 1) begin
        if (irq_pending) m_mode = 0;
      end else begin
        if (!ws) begin
          m_wlow++;
          if (m_wlow == WMIN) begin m_mode = 0; m_wlow = 0; end
        end else m_wlow = 0;
      end
      m_prev = es;
      ext_hist.push_front(ext_rst_pin_n); void'(ext_hist.pop_back());
      wake_hist.push_front(wake_pin_n);   void'(wake_hist.pop_back());
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && running) begin
      check(pin_pulldown_en == m_act, "R1 pulldown vs model", pin_pulldown_en, m_act);
      check(core_reset == (m_act || !ext_hist[1]), "R3 core_reset vs model", core_reset, m_act || !ext_hist[1]);
      check(mode == 2'(m_mode), "R10 mode vs model", mode, m_mode);
      check(test_mode == m_tm, "R6 test_mode vs model", test_mode, m_tm);
      check(reset_vector == (mem_internal ? 24'hFF2080 : 24'h0F2080), "R5 vector vs model",
            reset_vector, mem_internal ? 24'hFF2080 : 24'h0F2080);
      check(phase_clk_en == (m_mode != 2), "R9 phase vs model", phase_clk_en, m_mode != 2);
      check(osc_en == m_osc, "R9 osc vs model", osc_en, m_osc);
    end
  end

  initial begin
    state_tick = 0;
    forever begin
      @(negedge clk); state_tick = 1;
      @(negedge clk); state_tick = 0;
      @(negedge clk);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      if (!pin_pulldown_en) break;
      if (state_tick) n++;
    end
  endtask

  task automatic wait_release();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!core_reset) break;
    end
  endtask

  task automatic pulse_int();
    int_rst_req = 1; cyc(1); int_rst_req = 0;
  endtask

  initial begin
    int n;
    rst_n = 0; ext_rst_pin_n = 1; int_rst_req = 0; pd_enable = 0; pd_req = 0;
    idle_req = 0; irq_pending = 0; wake_pin_n = 1; strap_pin = 1; mem_internal = 1;
    cyc(3);
    check(pin_pulldown_en && core_reset, "R1 reset state pulldown", pin_pulldown_en, 1);
    check(mode == 2'b00 && !test_mode && osc_en, "R4 reset state mode", {mode, test_mode, osc_en}, 3'b001);
    rst_n = 1; running = 1;

    measure(n);
    check(n == WIN, "R1 power-up window ticks", n, WIN);
    cyc(1);
    check(!core_reset, "R3 released", core_reset, 0);
    check(!test_mode, "R6 strap high gives 0", test_mode, 0);
    check(reset_vector == 24'hFF2080, "R5 internal vector", reset_vector, 24'hFF2080);
    mem_internal = 0; #1;
    check(reset_vector == 24'h0F2080, "R5 external vector", reset_vector, 24'h0F2080);
    cyc(1); mem_internal = 1;

    // R1 internal trigger, R2 restart
    pulse_int();
    measure(n);
    check(n == WIN, "R1 internal trigger ticks", n, WIN);
    cyc(2);
    pulse_int();
    n = 0;
    while (n < 8) begin @(posedge clk); if (state_tick) n++; end
    @(negedge clk); int_rst_req = 1; @(negedge clk); int_rst_req = 0;
    measure(n);
    check(n == WIN, "R2 restart ticks", n, WIN);
    wait_release();

    // R3 long pin low, R6 strap low
    strap_pin = 0; ext_rst_pin_n = 0;
    cyc(80);
    check(!pin_pulldown_en && core_reset, "R3 reset held past window", {pin_pulldown_en, core_reset}, 2'b01);
    ext_rst_pin_n = 1;
    wait_release();
    strap_pin = 1; cyc(5);
    check(test_mode, "R6 strap low latched and held", test_mode, 1);
    pulse_int(); wait_release();
    check(!test_mode, "R6 strap high clears flag", test_mode, 0);

    // R7 powerdown gating
    pd_req = 1; cyc(1); pd_req = 0; cyc(2);
    check(mode == 2'b00, "R7 request ignored without enable", mode, 0);
    pd_enable = 1; pd_req = 1; cyc(1); pd_req = 0;
    check(mode == 2'b10 && !phase_clk_en && !osc_en, "R9 powerdown clocks off",
          {mode, phase_clk_en, osc_en}, 4'b1000);

    // R8 wake pin
    wake_pin_n = 0; cyc(2); wake_pin_n = 1; cyc(6);
    check(mode == 2'b10, "R8 short wake pulse ignored", mode, 2);
    wake_pin_n = 0; cyc(6); wake_pin_n = 1;
    check(mode == 2'b00 && !core_reset, "R8 wake exit without reset", {mode, core_reset}, 0);
    check(phase_clk_en && !osc_en, "R9 phase on osc off after wake", {phase_clk_en, osc_en}, 2'b10);

    // R10 idle
    idle_req = 1; cyc(1); idle_req = 0; cyc(5);
    check(mode == 2'b01, "R10 idle held", mode, 1);
    irq_pending = 1; cyc(1); irq_pending = 0;
    check(mode == 2'b00, "R10 interrupt leaves idle", mode, 0);
    pd_req = 1; idle_req = 1; cyc(1); pd_req = 0; idle_req = 0;
    check(mode == 2'b10, "R10 powerdown wins over idle", mode, 2);
    wake_pin_n = 0; cyc(5); wake_pin_n = 1; cyc(1);

    // R4 reset from idle and powerdown
    idle_req = 1; cyc(1); idle_req = 0;
    ext_rst_pin_n = 0; cyc(5);
    check(mode == 2'b00 && core_reset, "R4 pin reset leaves idle", {mode, core_reset}, 1);
    ext_rst_pin_n = 1; wait_release();
    check(osc_en, "R4 osc restored by reset", osc_en, 1);
    pd_req = 1; cyc(1); pd_req = 0;
    pulse_int(); cyc(1);
    check(mode == 2'b00 && osc_en, "R4 internal reset leaves powerdown", {mode, osc_en}, 1);
    idle_req = 1; cyc(4); idle_req = 0;
    wait_release(); cyc(1);
    check(mode == 2'b00, "R10 idle request during reset ignored", mode, 0);

    cyc(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule